// File: doc/BRIEF.md
# Pipelined YUV to RGB Color-Space Converter

This block turns one 8-bit luma sample and two 8-bit chroma samples per cycle into a saturated 8-bit red, green and blue triple. The luma sample first gets a signed offset and is clamped to the pixel range. The clamped value is then scaled by a gain shared by all three channels. Each output channel adds its own weighted blue-difference and red-difference chroma terms, rounds away the fraction bits and clamps the result once more to 0..255. The chroma inputs are unsigned and centred on 128.

Eight coefficient words set the conversion. Each word is 16 bits wide and holds its value in the low bits, in its own fixed-point format. Software writes the words through a small write port into a staging copy. The staging copy moves into the working set only on a cycle with no incoming pixel, so a pixel never sees a mix of two settings. A pixel accepted on a clock edge comes out three edges later, and the converter accepts one pixel on every edge.

Top module: `yuv2rgb_csc`

## Requirements
- R1: After reset `out_valid`, `out_r`, `out_g` and `out_b` are 0, and the working set is offset 0, gain 1.0 (word 0x0100) and every chroma weight 0, so each output channel equals the input luma.
- R2: A pixel sampled with `in_valid` high on a rising edge shows up with `out_valid` high right after the third rising edge (one pipeline register per stage, three stages). Pixels on consecutive edges come out on consecutive edges.
- R3: The adjusted luma is clamp(Y + offset, 0, 255), taken before the gain is applied. The offset is a two's-complement integer in bits [7:0] of its word.
- R4: Each chroma input is turned into the signed value (C - 128) before it is weighted.
- R5: Each channel equals clamp(floor((gain*L + wu*(U-128) + wv*(V-128) + 128) / 256), 0, 255). L is the adjusted luma, and wu and wv are that channel's own weights with 8 fraction bits.
- R6: Field layout: the gain is unsigned in bits [9:0] with 8 fraction bits. The red and blue weights are two's complement in bits [10:0] with the sign in bit 10. The green weights are two's complement in bits [9:0] with the sign in bit 9. The offset uses bits [7:0]. Bits above a field have no effect.
- R7: `cfg_sel` picks the word: 0 offset, 1 gain, 2 red U weight, 3 red V weight, 4 green U weight, 5 green V weight, 6 blue U weight, 7 blue V weight. A write lands in staging and marks an update pending. The pending update moves the whole staging set into the working set on the first rising edge at which `in_valid` is low. That edge copies staging as it stood before any write sampled on the same edge, and a write on that edge leaves the update pending.
- R8: Every pixel is converted with the working set that was in place when it was sampled, even if coefficient writes arrive while pixels are streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma, offset by 128 |
| in_v | input | 8 | Red-difference chroma, offset by 128 |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 3 | Coefficient word select (see R7) |
| cfg_data | input | 16 | Coefficient word, value in the low bits |
| out_valid | output | 1 | Output pixel present this cycle |
| out_r | output | 8 | Saturated red |
| out_g | output | 8 | Saturated green |
| out_b | output | 8 | Saturated blue |

## Verification
A coefficient write and a pixel acceptance can fall on the same edge. The hazard is that a write landing mid-stream changes the settings for pixels already in flight. The bench provokes this with back-to-back pixel bursts that carry writes on their first and middle beats, and with a long randomized stream of sparse pixels mixed with random writes. Its scoreboard model computes each pixel's colour from the settings it tracks as in force on the sampling edge, so a pixel converted with a half-applied or early update shows up as a miscompare.

// File: rtl/yuvc_pkg.sv
package yuvc_pkg;

  localparam int PIX_W    = 8;
  localparam int FRAC_W   = 8;
  localparam int CFG_W    = 16;
  localparam int NUM_COEF = 8;
  localparam int NUM_CH   = 3;
  localparam int SEL_W    = $clog2(NUM_COEF);

  // field widths inside a coefficient word
  localparam int OFS_FW = 8;
  localparam int GAIN_FW = 10;
  localparam int WG_FW  = 10;
  localparam int WRB_FW = 11;

  // normalized internal widths
  localparam int KW = 12;
  localparam int LW = PIX_W + 1;
  localparam int PW = KW + LW;
  localparam int AW = PW + 2;

  localparam logic [CFG_W-1:0]        UNITY_GAIN  = CFG_W'(1 << FRAC_W);
  localparam logic signed [LW-1:0]    CHROMA_BIAS = LW'(1 << (PIX_W - 1));
  localparam logic signed [AW-1:0]    ROUND_HALF  = AW'(1 << (FRAC_W - 1));
  localparam logic signed [AW-1:0]    PIX_MAX     = AW'((1 << PIX_W) - 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_OFS = 3'd0,
    SEL_GAIN = 3'd1,
    SEL_RU  = 3'd2,
    SEL_RV  = 3'd3,
    SEL_GU  = 3'd4,
    SEL_GV  = 3'd5,
    SEL_BU  = 3'd6,
    SEL_BV  = 3'd7
  } coef_sel_e;

  function automatic logic [CFG_W-1:0] reset_word(input int idx);
    return (idx == int'(SEL_GAIN)) ? UNITY_GAIN : '0;
  endfunction

  function automatic logic signed [KW-1:0] dec_offset(input logic [CFG_W-1:0] raw);
    return {{(KW-OFS_FW){raw[OFS_FW-1]}}, raw[OFS_FW-1:0]};
  endfunction

  function automatic logic signed [KW-1:0] dec_gain(input logic [CFG_W-1:0] raw);
    return {{(KW-GAIN_FW){1'b0}}, raw[GAIN_FW-1:0]};
  endfunction

  function automatic logic signed [KW-1:0] dec_wgreen(input logic [CFG_W-1:0] raw);
    return {{(KW-WG_FW){raw[WG_FW-1]}}, raw[WG_FW-1:0]};
  endfunction

  function automatic logic signed [KW-1:0] dec_wredblue(input logic [CFG_W-1:0] raw);
    return {{(KW-WRB_FW){raw[WRB_FW-1]}}, raw[WRB_FW-1:0]};
  endfunction

  function automatic logic [PIX_W-1:0] clamp_pix(input logic signed [AW-1:0] x);
    if (x[AW-1])          return '0;
    else if (x > PIX_MAX) return '1;
    else                  return x[PIX_W-1:0];
  endfunction

  function automatic logic [PIX_W-1:0] luma_offset(input logic [PIX_W-1:0] y,
                                                   input logic signed [KW-1:0] ofs);
    logic signed [AW-1:0] s;
    s = $signed({{(AW-PIX_W){1'b0}}, y}) + $signed({{(AW-KW){ofs[KW-1]}}, ofs});
    return clamp_pix(s);
  endfunction

  function automatic logic signed [LW-1:0] chroma_center(input logic [PIX_W-1:0] c);
    return $signed({1'b0, c}) - CHROMA_BIAS;
  endfunction

  function automatic logic signed [AW-1:0] round_shift(input logic signed [AW-1:0] acc);
    return (acc + ROUND_HALF) >>> FRAC_W;
  endfunction

endpackage

// File: rtl/yuvc_coef_bank.sv
module yuvc_coef_bank
  import yuvc_pkg::*;
#(
  parameter int N = NUM_COEF,
  parameter int W = CFG_W,
  localparam int SW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                cfg_we,
  input  logic [SW-1:0]       cfg_sel,
  input  logic [W-1:0]        cfg_data,
  output logic [N-1:0][W-1:0] act_words,
  output logic                commit,
  output logic                pending
);

  logic [N-1:0][W-1:0] stage_words;

  // working set may only change on an edge where no pixel is sampled
  assign commit = pending & ~in_valid;

  for (genvar e = 0; e < N; e++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_words[e] <= W'(reset_word(e));
        act_words[e]   <= W'(reset_word(e));
      end else begin
        if (cfg_we && (cfg_sel == SW'(e)))
          stage_words[e] <= cfg_data;
        if (commit)
          act_words[e] <= stage_words[e];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (cfg_we) pending <= 1'b1;
    else if (commit) pending <= 1'b0;
  end

endmodule

// File: rtl/yuvc_front.sv
module yuvc_front
  import yuvc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        in_y,
  input  logic [PIX_W-1:0]        in_u,
  input  logic [PIX_W-1:0]        in_v,
  input  logic signed [KW-1:0]    ofs,
  output logic                    s1_valid,
  output logic [PIX_W-1:0]        s1_luma,
  output logic signed [LW-1:0]    s1_u,
  output logic signed [LW-1:0]    s1_v
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_luma  <= '0;
      s1_u     <= '0;
      s1_v     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_luma <= luma_offset(in_y, ofs);
        s1_u    <= chroma_center(in_u);
        s1_v    <= chroma_center(in_v);
      end
    end
  end

endmodule

// File: rtl/yuvc_chan_mac.sv
module yuvc_chan_mac
  import yuvc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PIX_W-1:0]        s1_luma,
  input  logic signed [LW-1:0]    s1_u,
  input  logic signed [LW-1:0]    s1_v,
  input  logic signed [KW-1:0]    gain,
  input  logic signed [KW-1:0]    wu,
  input  logic signed [KW-1:0]    wv,
  output logic [PIX_W-1:0]        pix
);

  logic signed [LW-1:0] luma_s;
  logic signed [PW-1:0] p_y, p_u, p_v;
  logic signed [AW-1:0] acc;

  assign luma_s = $signed({1'b0, s1_luma});
  assign acc    = AW'(p_y) + AW'(p_u) + AW'(p_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_y <= '0;
      p_u <= '0;
      p_v <= '0;
      pix <= '0;
    end else begin
      p_y <= PW'(gain) * PW'(luma_s);
      p_u <= PW'(wu) * PW'(s1_u);
      p_v <= PW'(wv) * PW'(s1_v);
      pix <= clamp_pix(round_shift(acc));
    end
  end

endmodule

// File: rtl/yuv2rgb_csc.sv
module yuv2rgb_csc
  import yuvc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_y,
  input  logic [7:0]       in_u,
  input  logic [7:0]       in_v,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [15:0]      cfg_data,
  output logic             out_valid,
  output logic [7:0]       out_r,
  output logic [7:0]       out_g,
  output logic [7:0]       out_b
);

  logic [NUM_COEF-1:0][CFG_W-1:0] act_words;
  logic                           commit;
  logic                           pending;
  logic                           s1_valid;
  logic                           s2_valid;
  logic [PIX_W-1:0]               s1_luma;
  logic signed [LW-1:0]           s1_u, s1_v;
  logic signed [KW-1:0]           ofs_k, gain_k;
  logic [NUM_CH-1:0][PIX_W-1:0]   ch_pix;

  yuvc_coef_bank #(.N(NUM_COEF), .W(CFG_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .act_words(act_words),
    .commit   (commit),
    .pending  (pending)
  );

  assign ofs_k  = dec_offset(act_words[SEL_OFS]);
  assign gain_k = dec_gain(act_words[SEL_GAIN]);

  yuvc_front u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_y    (in_y),
    .in_u    (in_u),
    .in_v    (in_v),
    .ofs     (ofs_k),
    .s1_valid(s1_valid),
    .s1_luma (s1_luma),
    .s1_u    (s1_u),
    .s1_v    (s1_v)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int UIDX = int'(SEL_RU) + 2 * c;
    localparam int VIDX = UIDX + 1;
    logic signed [KW-1:0] wu_k, wv_k;

    if (c == 1) begin : g_green
      assign wu_k = dec_wgreen(act_words[UIDX]);
      assign wv_k = dec_wgreen(act_words[VIDX]);
    end else begin : g_rb
      assign wu_k = dec_wredblue(act_words[UIDX]);
      assign wv_k = dec_wredblue(act_words[VIDX]);
    end

    yuvc_chan_mac u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .s1_luma(s1_luma),
      .s1_u   (s1_u),
      .s1_v   (s1_v),
      .gain   (gain_k),
      .wu     (wu_k),
      .wv     (wv_k),
      .pix    (ch_pix[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s2_valid  <= s1_valid;
      out_valid <= s2_valid;
    end
  end

  assign out_r = ch_pix[0];
  assign out_g = ch_pix[1];
  assign out_b = ch_pix[2];

endmodule

// File: rtl/yuvc_checker.sv
module yuvc_checker
  import yuvc_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           cfg_we,
  input logic                           commit,
  input logic                           pending,
  input logic                           s1_valid,
  input logic                           s2_valid,
  input logic                           out_valid,
  input logic [NUM_COEF-1:0][CFG_W-1:0] act_words
);

  // R2: one register per stage, valid moves in step
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  a_r2_no_ghost: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !s1_valid);
  a_r2_mid: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> s2_valid);
  a_r2_exit: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> out_valid);
  a_r2_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> !out_valid);

  // R7: update only in a gap, only when pending, and it drains
  a_r7_commit_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !in_valid);
  a_r7_commit_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> pending);
  a_r7_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> pending);
  a_r7_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !in_valid && !cfg_we) |=> !pending);

  // R8: the working set holds across any edge that samples a pixel
  a_r8_hold_on_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $stable(act_words));

endmodule

bind yuv2rgb_csc yuvc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .cfg_we   (cfg_we),
  .commit   (commit),
  .pending  (pending),
  .s1_valid (s1_valid),
  .s2_valid (s2_valid),
  .out_valid(out_valid),
  .act_words(act_words)
);

// File: tb/yuv2rgb_csc_tb.sv
module yuv2rgb_csc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  always #5 clk = ~clk;

  yuv2rgb_csc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  typedef struct {
    int    r, g, b;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_tag = "";
  int    m_act[8];
  int    m_stg[8];
  bit    m_pend;

  // --- reference arithmetic, written from the requirements ---
  function automatic int field_val(int sel, int raw);
    int x;
    case (sel)
      0:       begin x = raw & 255;  if (x >= 128)  x -= 256;  end
      1:       x = raw & 1023;
      4, 5:    begin x = raw & 1023; if (x >= 512)  x -= 1024; end
      default: begin x = raw & 2047; if (x >= 1024) x -= 2048; end
    endcase
    return x;
  endfunction

  function automatic int clip(int x);
    return (x < 0) ? 0 : ((x > 255) ? 255 : x);
  endfunction

  function automatic int ref_chan(int y, int u, int v, int wsel);
    int lum, sum;
    lum = clip(y + field_val(0, m_act[0]));
    sum = field_val(1, m_act[1]) * lum
        + field_val(wsel, m_act[wsel]) * (u - 128)
        + field_val(wsel + 1, m_act[wsel + 1]) * (v - 128) + 128;
    return clip(sum >>> 8);
  endfunction

  // scoreboard model: follows sampled inputs on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_act[i] = (i == 1) ? 256 : 0;
        m_stg[i] = m_act[i];
      end
      m_pend = 0;
    end else begin
      if (in_valid) begin
        exp_t e;
        e.r = ref_chan(in_y, in_u, in_v, 2);
        e.g = ref_chan(in_y, in_u, in_v, 4);
        e.b = ref_chan(in_y, in_u, in_v, 6);
        e.tag = cur_tag;
        sb.push_back(e);
      end
      if (m_pend && !in_valid) begin
        for (int i = 0; i < 8; i++) m_act[i] = m_stg[i];
        m_pend = 0;
      end
      if (cfg_we) begin
        m_stg[cfg_sel] = int'(cfg_data);
        m_pend = 1;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      n_checks++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected output: got %0d/%0d/%0d expected none",
                 out_r, out_g, out_b);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (out_r != e.r[7:0] || out_g != e.g[7:0] || out_b != e.b[7:0]) begin
          n_fail++;
          $display("FAIL %s: got rgb %0d/%0d/%0d expected %0d/%0d/%0d",
                   e.tag, out_r, out_g, out_b, e.r, e.g, e.b);
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  // one cycle of stimulus, applied at the falling edge
  task automatic step(bit v, int y, int u, int c, bit we, int sel, int data, string tag);
    @(negedge clk);
    in_valid = v;
    in_y = y[7:0]; in_u = u[7:0]; in_v = c[7:0];
    cfg_we = we; cfg_sel = sel[2:0]; cfg_data = data[15:0];
    cur_tag = tag;
  endtask

  task automatic px(int y, int u, int c, string tag);
    step(1, y, u, c, 0, 0, 0, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 128, 128, 0, 0, 0, "");
  endtask

  task automatic set_coef(int sel, int data);
    step(0, 0, 128, 128, 1, sel, data, "");
    idle(1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 0 && out_r == 0 && out_g == 0 && out_b == 0, "R1 reset outputs",
          int'(out_valid) + int'(out_r), 0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 0, "R1 idle after reset", int'(out_valid), 0);

    // R1: default set passes luma through
    px(0, 17, 240, "R1 identity");
    px(77, 0, 0, "R1 identity");
    px(255, 255, 255, "R1 identity");

    // R2: exact latency of one pixel
    idle(4);
    step(1, 100, 128, 128, 0, 0, 0, "R2 latency");
    idle(1);
    check(out_valid == 0, "R2 after edge 1", int'(out_valid), 0);
    idle(1);
    check(out_valid == 0, "R2 after edge 2", int'(out_valid), 0);
    idle(1);
    check(out_valid == 1, "R2 after edge 3", int'(out_valid), 1);
    idle(3);

    // R3: offset saturates before the gain (gain 0.5)
    set_coef(1, 16'h0080);
    set_coef(0, 16'h007F);
    px(200, 128, 128, "R3 high clamp before gain");
    px(1, 128, 128, "R3 in-range offset");
    idle(1);
    set_coef(0, 16'h0080);
    px(10, 128, 128, "R3 low clamp");
    px(255, 128, 128, "R3 negative offset");
    idle(1);

    // R5: round half up (gain 0.5, offset 0)
    set_coef(0, 16'h0000);
    px(1, 128, 128, "R5 rounding");
    px(3, 128, 128, "R5 rounding");

    // R4/R5: chroma centring and channel clamps
    idle(1);
    set_coef(1, 16'h0000);
    set_coef(3, 16'h0100);
    set_coef(4, 16'h0300);
    px(0, 128, 200, "R4 v centred");
    px(0, 128, 128, "R4 zero chroma");
    px(0, 0, 0, "R5 low clamp");
    px(0, 255, 255, "R4 u weight green");
    idle(1);
    set_coef(3, 16'h03FF);
    px(0, 128, 255, "R5 high clamp");

    // R6: studio-range set, written with junk in the pad bits
    idle(1);
    set_coef(0, 16'h5AF0);
    set_coef(1, 16'hFD2A);
    set_coef(2, 16'hF800);
    set_coef(3, 16'hA199);
    set_coef(4, 16'hFF9C);
    set_coef(5, 16'h0330);
    set_coef(6, 16'h5204);
    set_coef(7, 16'h0000);
    px(16, 128, 128, "R6 pad bits ignored");
    px(235, 128, 128, "R6 pad bits ignored");
    px(81, 90, 240, "R6 pad bits ignored");
    px(145, 54, 34, "R6 pad bits ignored");
    px(41, 240, 110, "R6 pad bits ignored");

    // R7/R8: writes during a back-to-back burst take effect only after a gap
    step(1, 120, 60, 200, 1, 3, 16'h0000, "R8 write on first beat");
    px(120, 60, 200, "R8 burst keeps old set");
    step(1, 130, 70, 190, 1, 1, 16'h0100, "R8 write mid burst");
    px(140, 80, 180, "R8 burst keeps old set");
    step(0, 0, 128, 128, 1, 0, 16'h0000, "");
    px(120, 60, 200, "R7 gap edge with write");
    idle(1);
    px(120, 60, 200, "R7 second gap applied");

    // R8: randomized stream with random writes
    for (int i = 0; i < 1500; i++) begin
      bit v, w;
      v = ($urandom % 10) < 7;
      w = ($urandom % 12) == 0;
      step(v, $urandom % 256, $urandom % 256, $urandom % 256,
           w, $urandom % 8, $urandom % 65536, "R8 random stream");
    end

    idle(8);
    check(sb.size() == 0, "R2 all pixels returned", sb.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule